// File: doc/BRIEF.md
# Multi-Kernel Workgroup Dispatch Scheduler

This block hands out workgroups from several launched kernels to a pool of compute resources. Each launch takes a free kernel slot and gives its 3-D workgroup counts. The slot number becomes the kernel ID. Launched kernels wait in an ID queue in launch order. A dispatch pass offers workgroups from the head kernel one at a time over a valid/ready handshake. When the resources refuse an offer, the kernel moves to the back of the queue so that the kernels behind it can still make progress.

The environment reports each finished workgroup together with its kernel ID. The block counts these reports for each kernel. When a kernel's count reaches its total, the block frees the slot, pulses a done output and, if the launch asked for it, a notify output. It also keeps a count of outstanding kernels. At the end of a pass in which kernels have finished, the block raises one host wake-up pulse.

Top module: `wg_dispatch_sched`

## Requirements
- R1: A launch is taken only when `launch_ready` is high, which requires that no pass is running and that a slot is free. The kernel gets the lowest-numbered free slot as its ID, shown on `launch_kid` while the launch is offered. Kernels enter the queue in launch order.
- R2: During a pass, the head kernel is offered on `wg_valid`, one workgroup per cycle, for as long as each offer is accepted. The index starts at (0,0,0) and advances x first, then y, then z.
- R3: A refused offer moves the head kernel to the tail of the queue and adds one to the fail count of the pass. The pass ends once the queue length is no larger than that count, so a blocked kernel never stops a later kernel in the queue from issuing.
- R4: Once its last workgroup is accepted, a kernel leaves the queue and is never offered again.
- R5: An accepted launch, or a completion for an active kernel, makes a pass start on the following cycle unless a pass request is already pending. `wg_valid` is high only while `pass_active` is high.
- R6: Each completion for an active kernel adds one to that kernel's count. The completion that makes the count equal the kernel's total workgroups (nx*ny*nz) produces a one-cycle `kern_done` pulse with that ID on the next cycle and frees the slot.
- R7: `outstanding` goes up by one for each accepted launch and down by one for each finished kernel.
- R8: A kernel launched with `launch_notify` high also pulses `notify_valid`, with its ID on `notify_kid`, in the same cycle as its `kern_done` pulse. A kernel launched without the flag does not.
- R9: A pass that ends with at least one kernel finished since the previous wake-up raises `host_wake` for exactly one cycle. A pass with no finished kernels raises nothing.
- R10: A completion naming a kernel ID that is not active sets `cpl_error`, which stays set until reset. Such a completion changes no count, produces no `kern_done` pulse and does not change `outstanding`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| launch_valid | input | 1 | Launch request |
| launch_ready | output | 1 | Launch can be accepted |
| launch_kid | output | KW | ID the launch will receive |
| launch_nx | input | DW | Workgroups in x (nonzero) |
| launch_ny | input | DW | Workgroups in y (nonzero) |
| launch_nz | input | DW | Workgroups in z (nonzero) |
| launch_notify | input | 1 | Request a notify pulse on completion |
| wg_valid | output | 1 | Workgroup offer |
| wg_ready | input | 1 | Resources accept the offer |
| wg_kid | output | KW | Kernel of the offered workgroup |
| wg_x | output | DW | Workgroup x index |
| wg_y | output | DW | Workgroup y index |
| wg_z | output | DW | Workgroup z index |
| cpl_valid | input | 1 | Workgroup finished |
| cpl_kid | input | KW | Kernel of the finished workgroup |
| kern_done | output | 1 | Kernel finished pulse |
| kern_done_kid | output | KW | ID of the finished kernel |
| notify_valid | output | 1 | Notify pulse |
| notify_kid | output | KW | ID for the notify |
| outstanding | output | KW+1 | Launched kernels not yet finished |
| host_wake | output | 1 | Host wake-up pulse |
| pass_active | output | 1 | Dispatch pass in progress |
| cpl_error | output | 1 | Sticky completion-to-inactive-kernel flag |

## Verification
The bench blocks the first kernel and launches a second one behind it. A design that stalls on the blocked head would never issue the second kernel's workgroups. A design that drops a refused kernel instead of rotating it would never issue the first kernel once resources free up.

A 2x2x2 kernel checks the index order: a wrong nesting shows up as a swapped tuple on the scoreboard. The monitor also catches any workgroup issued after a kernel's last one, which exposes a kernel kept in the queue.

On the completion side, the bench checks the following:
- the done pulse comes only on the final completion;
- exactly one wake-up occurs per finishing pass;
- the notify flag follows each kernel;
- a stray completion raises the error without touching `outstanding`.

Filling every slot checks that `launch_ready` drops.

// File: rtl/wg_dispatch_sched.sv
module wg_dispatch_sched #(
  parameter int NK = 4,
  parameter int DW = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    launch_valid,
  output logic                    launch_ready,
  output logic [$clog2(NK)-1:0]   launch_kid,
  input  logic [DW-1:0]           launch_nx,
  input  logic [DW-1:0]           launch_ny,
  input  logic [DW-1:0]           launch_nz,
  input  logic                    launch_notify,
  output logic                    wg_valid,
  input  logic                    wg_ready,
  output logic [$clog2(NK)-1:0]   wg_kid,
  output logic [DW-1:0]           wg_x,
  output logic [DW-1:0]           wg_y,
  output logic [DW-1:0]           wg_z,
  input  logic                    cpl_valid,
  input  logic [$clog2(NK)-1:0]   cpl_kid,
  output logic                    kern_done,
  output logic [$clog2(NK)-1:0]   kern_done_kid,
  output logic                    notify_valid,
  output logic [$clog2(NK)-1:0]   notify_kid,
  output logic [$clog2(NK):0]     outstanding,
  output logic                    host_wake,
  output logic                    pass_active,
  output logic                    cpl_error
);
  localparam int KW = $clog2(NK);
  localparam int CW = KW + 1;
  localparam int TW = 3 * DW;

  logic [DW-1:0] nx [NK];
  logic [DW-1:0] ny [NK];
  logic [DW-1:0] nz [NK];
  logic [DW-1:0] ix [NK];
  logic [DW-1:0] iy [NK];
  logic [DW-1:0] iz [NK];
  logic [TW-1:0] tot [NK];
  logic [TW-1:0] ndone [NK];
  logic [NK-1:0] act, ntf, done_list;

  logic [KW-1:0] q [NK];
  logic [KW-1:0] qh, qt;
  logic [CW-1:0] qcnt, fail;
  logic          busy, pend;

  logic          free_found;
  logic [KW-1:0] free_kid;

  always_comb begin
    free_found = 1'b0;
    free_kid   = '0;
    for (int i = NK - 1; i >= 0; i--) begin
      if (!act[i]) begin
        free_found = 1'b1;
        free_kid   = KW'(i);
      end
    end
  end

  wire [KW-1:0] hk = q[qh];
  wire go       = busy && (qcnt > fail);
  wire h_last   = (ix[hk] == nx[hk] - DW'(1)) && (iy[hk] == ny[hk] - DW'(1)) &&
                  (iz[hk] == nz[hk] - DW'(1));
  wire accept   = go && wg_ready;
  wire refuse   = go && !wg_ready;
  wire pop      = refuse || (accept && h_last);

  wire launch_fire = launch_valid && launch_ready;
  wire push        = launch_fire || refuse;
  wire pass_start  = !busy && pend;
  wire pass_end    = busy && !go;

  wire cpl_hit = cpl_valid && act[cpl_kid];
  wire cpl_fin = cpl_hit && (ndone[cpl_kid] + TW'(1) == tot[cpl_kid]);

  assign launch_ready = !busy && free_found;
  assign launch_kid   = free_kid;
  assign wg_valid     = go;
  assign wg_kid       = hk;
  assign wg_x         = ix[hk];
  assign wg_y         = iy[hk];
  assign wg_z         = iz[hk];
  assign pass_active  = busy;

  function automatic logic [KW-1:0] nxt(input logic [KW-1:0] p);
    return (p == KW'(NK - 1)) ? '0 : p + KW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      pend <= 1'b0;
      fail <= '0;
      qh <= '0;
      qt <= '0;
      qcnt <= '0;
      act <= '0;
      ntf <= '0;
      done_list <= '0;
      kern_done <= 1'b0;
      kern_done_kid <= '0;
      notify_valid <= 1'b0;
      notify_kid <= '0;
      outstanding <= '0;
      host_wake <= 1'b0;
      cpl_error <= 1'b0;
      for (int i = 0; i < NK; i++) begin
        q[i] <= '0;
        nx[i] <= '0;
        ny[i] <= '0;
        nz[i] <= '0;
        ix[i] <= '0;
        iy[i] <= '0;
        iz[i] <= '0;
        tot[i] <= '0;
        ndone[i] <= '0;
      end
    end else begin
      pend <= (pend && !pass_start) || launch_fire || cpl_hit;
      if (pass_start)    busy <= 1'b1;
      else if (pass_end) busy <= 1'b0;
      fail <= pass_start ? '0 : fail + CW'(refuse);

      if (push) begin
        q[qt] <= launch_fire ? free_kid : hk;
        qt    <= nxt(qt);
      end
      if (pop) qh <= nxt(qh);
      qcnt <= qcnt + CW'(push) - CW'(pop);

      if (launch_fire) begin
        act[free_kid]   <= 1'b1;
        ntf[free_kid]   <= launch_notify;
        nx[free_kid]    <= launch_nx;
        ny[free_kid]    <= launch_ny;
        nz[free_kid]    <= launch_nz;
        ix[free_kid]    <= '0;
        iy[free_kid]    <= '0;
        iz[free_kid]    <= '0;
        ndone[free_kid] <= '0;
        tot[free_kid]   <= TW'(launch_nx) * TW'(launch_ny) * TW'(launch_nz);
      end

      if (accept && !h_last) begin
        if (ix[hk] != nx[hk] - DW'(1)) begin
          ix[hk] <= ix[hk] + DW'(1);
        end else begin
          ix[hk] <= '0;
          if (iy[hk] != ny[hk] - DW'(1)) begin
            iy[hk] <= iy[hk] + DW'(1);
          end else begin
            iy[hk] <= '0;
            iz[hk] <= iz[hk] + DW'(1);
          end
        end
      end

      if (cpl_hit) begin
        if (cpl_fin) act[cpl_kid] <= 1'b0;
        else         ndone[cpl_kid] <= ndone[cpl_kid] + TW'(1);
      end
      if (cpl_valid && !act[cpl_kid]) cpl_error <= 1'b1;

      done_list <= (pass_end ? '0 : done_list) |
                   (cpl_fin ? (NK'(1) << cpl_kid) : '0);
      host_wake     <= pass_end && (|done_list);
      kern_done     <= cpl_fin;
      kern_done_kid <= cpl_kid;
      notify_valid  <= cpl_fin && ntf[cpl_kid];
      notify_kid    <= cpl_kid;
      outstanding   <= outstanding + CW'(launch_fire) - CW'(cpl_fin);
    end
  end
endmodule

// File: rtl/wg_dispatch_sched_chk.sv
module wg_dispatch_sched_chk #(
  parameter int NK = 4,
  parameter int DW = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  launch_valid,
  input logic                  launch_ready,
  input logic                  wg_valid,
  input logic                  cpl_valid,
  input logic                  kern_done,
  input logic [$clog2(NK)-1:0] kern_done_kid,
  input logic                  notify_valid,
  input logic [$clog2(NK)-1:0] notify_kid,
  input logic [$clog2(NK):0]   outstanding,
  input logic                  host_wake,
  input logic                  pass_active,
  input logic                  cpl_error
);
  localparam int CW = $clog2(NK) + 1;

  a_r5_offer_in_pass: assert property (@(posedge clk) disable iff (!rst_n)
    wg_valid |-> pass_active);

  a_r1_no_launch_in_pass: assert property (@(posedge clk) disable iff (!rst_n)
    launch_ready |-> !pass_active);

  a_r7_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding <= CW'(NK));

  a_r7_done_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    (kern_done && !$past(launch_valid && launch_ready)) |->
      outstanding == $past(outstanding) - CW'(1));

  a_r8_notify_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid |-> (kern_done && notify_kid == kern_done_kid));

  a_r9_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
    host_wake |=> !host_wake);

  a_r10_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_error |=> cpl_error);

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    (kern_done && !$past(cpl_valid, 2)) |=> !(kern_done && $stable(kern_done_kid)));
endmodule

bind wg_dispatch_sched wg_dispatch_sched_chk #(.NK(NK), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .launch_valid(launch_valid), .launch_ready(launch_ready),
  .wg_valid(wg_valid), .cpl_valid(cpl_valid), .kern_done(kern_done),
  .kern_done_kid(kern_done_kid), .notify_valid(notify_valid), .notify_kid(notify_kid),
  .outstanding(outstanding), .host_wake(host_wake), .pass_active(pass_active),
  .cpl_error(cpl_error)
);

// File: tb/sim_wg_dispatch_sched.sv
module sim_wg_dispatch_sched;
  localparam int NK = 4;
  localparam int DW = 4;
  localparam int KW = 2;
  localparam int IW = KW + 3 * DW;

  logic clk = 0, rst_n = 0;
  logic launch_valid = 0, launch_notify = 0, cpl_valid = 0;
  logic [DW-1:0] launch_nx = 1, launch_ny = 1, launch_nz = 1;
  logic [KW-1:0] cpl_kid = 0;
  logic [NK-1:0] allow = '1;
  logic launch_ready, wg_valid, wg_ready, kern_done, notify_valid, host_wake, pass_active, cpl_error;
  logic [KW-1:0] launch_kid, wg_kid, kern_done_kid, notify_kid;
  logic [DW-1:0] wg_x, wg_y, wg_z;
  logic [KW:0] outstanding;

  int nchk = 0, nfail = 0, wake_cnt = 0;
  logic [IW-1:0] exp_wg [$];
  logic [KW:0]   exp_done [$];

  always #10 clk = ~clk;
  assign wg_ready = allow[wg_kid];

  wg_dispatch_sched #(.NK(NK), .DW(DW)) u0 (.*);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (wg_valid && wg_ready) begin
      if (exp_wg.size() == 0) chk(0, "R4", "unexpected workgroup issue", int'({wg_kid, wg_x, wg_y, wg_z}), -1);
      else begin
        logic [IW-1:0] e;
        e = exp_wg.pop_front();
        chk({wg_kid, wg_x, wg_y, wg_z} == e, "R2", "workgroup {kid,x,y,z}",
            int'({wg_kid, wg_x, wg_y, wg_z}), int'(e));
      end
    end
    if (kern_done) begin
      if (exp_done.size() == 0) chk(0, "R10", "unexpected kern_done", int'(kern_done_kid), -1);
      else begin
        logic [KW:0] d;
        d = exp_done.pop_front();
        chk(kern_done_kid == d[KW-1:0], "R6", "done kid", int'(kern_done_kid), int'(d[KW-1:0]));
        chk(notify_valid == d[KW], "R8", "notify flag", int'(notify_valid), int'(d[KW]));
      end
    end else if (notify_valid) chk(0, "R8", "notify without done", 1, 0);
    if (host_wake) wake_cnt++;
  end

  task automatic launch(input int x, input int y, input int z, input bit ntf, input int kid);
    int n = 0;
    @(negedge clk);
    while (!launch_ready && n < 50) begin @(negedge clk); n++; end
    chk(launch_ready, "R1", "launch_ready", int'(launch_ready), 1);
    chk(launch_kid == KW'(kid), "R1", "launch_kid", int'(launch_kid), kid);
    launch_nx = DW'(x); launch_ny = DW'(y); launch_nz = DW'(z); launch_notify = ntf;
    launch_valid = 1;
    @(negedge clk);
    launch_valid = 0;
  endtask

  task automatic cpl(input int kid);
    cpl_kid = KW'(kid); cpl_valid = 1;
    @(negedge clk);
    cpl_valid = 0;
  endtask

  task automatic settle();
    int n = 0;
    while (exp_wg.size() != 0 && n < 100) begin @(negedge clk); n++; end
    repeat (6) @(negedge clk);
    chk(exp_wg.size() == 0, "R2", "pending expected issues", exp_wg.size(), 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(launch_ready == 1 && launch_kid == 0, "R1", "reset launch_ready", int'(launch_ready), 1);
    chk(wg_valid == 0 && pass_active == 0, "R5", "reset idle", int'(pass_active), 0);
    chk(outstanding == 0 && cpl_error == 0 && host_wake == 0, "R7", "reset counters", int'(outstanding), 0);

    // R2 index order on a 2x2x2 kernel with notify
    for (int z = 0; z < 2; z++)
      for (int y = 0; y < 2; y++)
        for (int x = 0; x < 2; x++)
          exp_wg.push_back({KW'(0), DW'(x), DW'(y), DW'(z)});
    launch(2, 2, 2, 1, 0);
    chk(outstanding == 1, "R7", "outstanding after launch", int'(outstanding), 1);
    settle();
    for (int i = 0; i < 7; i++) cpl(0);
    repeat (4) @(negedge clk);
    chk(outstanding == 1, "R6", "no finish before final completion", int'(outstanding), 1);
    chk(wake_cnt == 0, "R9", "no wake without finished kernel", wake_cnt, 0);
    exp_done.push_back({1'b1, KW'(0)});
    cpl(0);
    repeat (6) @(negedge clk);
    chk(outstanding == 0, "R7", "outstanding after finish", int'(outstanding), 0);
    chk(wake_cnt == 1, "R9", "one wake after finish", wake_cnt, 1);
    chk(exp_done.size() == 0, "R6", "done seen", exp_done.size(), 0);

    // R3 rotation past a blocked kernel
    allow = 4'b1110;
    launch(2, 1, 1, 0, 0);
    repeat (6) @(negedge clk);
    chk(pass_active == 0, "R3", "pass ends with blocked kernel", int'(pass_active), 0);
    exp_wg.push_back({KW'(1), DW'(0), DW'(0), DW'(0)});
    exp_wg.push_back({KW'(1), DW'(0), DW'(1), DW'(0)});
    launch(1, 2, 1, 0, 1);
    settle();
    chk(outstanding == 2, "R7", "two outstanding", int'(outstanding), 2);
    allow = 4'b1111;
    exp_wg.push_back({KW'(0), DW'(0), DW'(0), DW'(0)});
    exp_wg.push_back({KW'(0), DW'(1), DW'(0), DW'(0)});
    exp_done.push_back({1'b0, KW'(1)});
    cpl(1);
    cpl(1);
    settle();
    chk(wake_cnt == 2, "R9", "wake after second kernel", wake_cnt, 2);
    exp_done.push_back({1'b0, KW'(0)});
    cpl(0);
    cpl(0);
    repeat (6) @(negedge clk);
    chk(outstanding == 0, "R7", "all finished", int'(outstanding), 0);
    chk(wake_cnt == 3, "R9", "third wake", wake_cnt, 3);

    // R10 completion for an inactive kernel
    cpl(2);
    repeat (4) @(negedge clk);
    chk(cpl_error == 1, "R10", "error flag set", int'(cpl_error), 1);
    chk(outstanding == 0, "R10", "outstanding unchanged", int'(outstanding), 0);
    chk(wake_cnt == 3, "R10", "no wake from stray completion", wake_cnt, 3);

    // R1 fill all slots while blocked
    allow = '0;
    for (int k = 0; k < NK; k++) launch(1, 1, 1, 0, k);
    repeat (10) @(negedge clk);
    chk(launch_ready == 0, "R1", "launch_ready low when full", int'(launch_ready), 0);
    chk(outstanding == NK, "R7", "outstanding when full", int'(outstanding), NK);
    chk(cpl_error == 1, "R10", "error stays set", int'(cpl_error), 1);

    summary();
    $finish;
  end
endmodule